// File: doc/BRIEF.md
# SCSI Selection Collision Handler

This block follows a SCSI controller while it tries to win the bus toward another device. In the initiator role that attempt is a selection of a target. In the target role it is a reselection of an initiator. A bus monitor reports, one cycle at a time, that some other device is selecting this controller or reselecting it. Two configuration bits decide whether the block answers each kind of event. An answered event that arrives while an attempt is pending cancels that attempt. The block then gives the instruction sequencer a one-cycle request to jump to an alternate address, which was captured when the attempt began.

An answered event does three further things. It sets a sticky status flag, selected or reselected. It moves the operating role to the one the event implies. It marks the role as unconfirmed. No new attempt is accepted until software sets the role again through one of the two role strobes. Each status flag has an interrupt enable at the same bit position, and the interrupt output is raised when any enabled flag is set. Bus arbitration timing, the decode of the ID on the data lines, and the sequencer itself stay outside this block.

Top module: `bus_collide_unit`

## Requirements
- R1: After synchronous reset the outputs are as follows: `stat_q` = 0, `irq` = 0, `busy` = 0, `alt_jump` = 0, `done_pulse` = 0, `role_tgt` = 0 (initiator) and `role_ok` = 1. Both response enables and both interrupt enables are cleared.
- R2: A `start_req` is accepted when `busy` = 0, `role_ok` = 1 and no answered bus event occurs in the same cycle. When accepted, `busy` reads 1 from the next cycle and `start_alt` is captured. A `start_req` made while busy is ignored, and so is one made while the role is unconfirmed; in both cases the captured address does not change.
- R3: In the initiator role with an attempt pending, an answered reselection does the following. It raises `alt_jump` for exactly one cycle. It drives `alt_addr` with the captured address during that cycle. It clears `busy` in that same cycle.
- R4: In the target role with an attempt pending, an answered selection raises the same one-cycle `alt_jump` with the captured `alt_addr` and clears `busy`.
- R5: The response enables come from `cfg_wdata` bit 5 (selection) and bit 6 (reselection). An event whose enable bit is 0 is ignored: no flag is set, no jump occurs, the role does not change and any pending attempt continues. With only bit 5 set, a reselection therefore never takes effect.
- R6: `stat_q` bit 5 is the selected flag and bit 4 is the reselected flag. All other bits read 0. A flag is set from the cycle after an answered event and stays set until a `stat_rd` strobe. If a flag is set and cleared in the same cycle, the set wins for that flag, and the other flag is still cleared.
- R7: The interrupt enables come from `ien_wdata`: bit 5 for the selected flag and bit 4 for the reselected flag. `irq` is 1 exactly when some flag is set and its enable bit is 1.
- R8: An answered selection moves the role to target. An answered reselection moves it to initiator. If both are answered in the same cycle, target wins and both flags are set. Any answered event clears `role_ok`. `role_ok` is set again only by `set_init` or `set_tgt`, and if both strobes are given together, `set_tgt` wins.
- R9: If an answered event and `attempt_done` fall in the same cycle of a pending attempt, the collision wins. `alt_jump` pulses and `done_pulse` stays 0.
- R10: An `attempt_done` during a pending attempt with no answered event raises `done_pulse` for one cycle and clears `busy`. No jump occurs in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the response-enable register |
| cfg_wdata | input | REG_W | Response enables: bit 5 selection, bit 6 reselection |
| ien_we | input | 1 | Write strobe for the interrupt-enable register |
| ien_wdata | input | REG_W | Interrupt enables: bit 5 selected, bit 4 reselected |
| set_init | input | 1 | Confirm role as initiator |
| set_tgt | input | 1 | Confirm role as target (wins over set_init) |
| start_req | input | 1 | Begin a (re)selection attempt in the current role |
| start_alt | input | ADDR_W | Alternate sequencer address captured at start |
| attempt_done | input | 1 | Bus monitor: the attempt completed normally |
| mon_sel | input | 1 | Bus monitor: this controller is being selected |
| mon_resel | input | 1 | Bus monitor: this controller is being reselected |
| stat_rd | input | 1 | Read-to-clear strobe for the status flags |
| stat_q | output | REG_W | Status: bit 5 selected, bit 4 reselected |
| irq | output | 1 | Interrupt request |
| role_tgt | output | 1 | Operating role: 0 initiator, 1 target |
| role_ok | output | 1 | Role has been confirmed since the last answered event |
| busy | output | 1 | An attempt is pending |
| alt_jump | output | 1 | One-cycle request to jump to the alternate address |
| alt_addr | output | ADDR_W | Captured alternate address |
| done_pulse | output | 1 | One-cycle normal completion of an attempt |

## Verification
A collision and the normal completion of an attempt can land on the same clock edge. The bench starts an attempt and then raises `mon_resel` and `attempt_done` together in a single cycle. In the next cycle it expects `alt_jump` high, `done_pulse` low and `busy` cleared. A second same-cycle case sets a status flag and pulses the read-to-clear strobe at once, and checks that the set survives while the other flag is cleared.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  localparam int SEL_EN_BIT     = 5;
  localparam int RESEL_EN_BIT   = 6;
  localparam int STAT_SEL_BIT   = 5;
  localparam int STAT_RESEL_BIT = 4;

  typedef enum logic {
    ROLE_INIT = 1'b0,
    ROLE_TGT  = 1'b1
  } role_e;

  typedef struct packed {
    logic sel;
    logic resel;
  } evt_t;
endpackage

// File: rtl/bcu_cfg_regs.sv
module bcu_cfg_regs
  import bcu_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             ien_we,
  input  logic [REG_W-1:0] ien_wdata,
  output evt_t             resp_en,
  output evt_t             int_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_en <= '0;
      int_en  <= '0;
    end else begin
      if (cfg_we) begin
        resp_en.sel   <= cfg_wdata[SEL_EN_BIT];
        resp_en.resel <= cfg_wdata[RESEL_EN_BIT];
      end
      if (ien_we) begin
        int_en.sel   <= ien_wdata[STAT_SEL_BIT];
        int_en.resel <= ien_wdata[STAT_RESEL_BIT];
      end
    end
  end
endmodule

// File: rtl/bcu_event_arb.sv
module bcu_event_arb
  import bcu_pkg::*;
(
  input  logic mon_sel,
  input  logic mon_resel,
  input  evt_t resp_en,
  input  logic busy,
  input  logic attempt_done,
  output evt_t accepted,
  output logic collide,
  output logic finish
);
  always_comb begin
    accepted.sel   = mon_sel & resp_en.sel;
    accepted.resel = mon_resel & resp_en.resel;
    collide        = busy & (accepted.sel | accepted.resel);
    finish         = busy & attempt_done & ~collide;
  end
endmodule

// File: rtl/bcu_status.sv
module bcu_status
  import bcu_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  evt_t             accepted,
  input  logic             stat_rd,
  input  evt_t             int_en,
  output logic [REG_W-1:0] stat_q,
  output logic             irq
);
  evt_t flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else begin
      flags.sel   <= accepted.sel   | (flags.sel   & ~stat_rd);
      flags.resel <= accepted.resel | (flags.resel & ~stat_rd);
    end
  end

  always_comb begin
    for (int i = 0; i < REG_W; i++) begin
      stat_q[i] = 1'b0;
    end
    stat_q[STAT_SEL_BIT]   = flags.sel;
    stat_q[STAT_RESEL_BIT] = flags.resel;
  end

  assign irq = (flags.sel & int_en.sel) | (flags.resel & int_en.resel);

  AST_FLAG_STICKY_SEL: assert property (@(posedge clk) disable iff (rst)
    (flags.sel && !stat_rd) |=> flags.sel); // R6
  AST_FLAG_STICKY_RESEL: assert property (@(posedge clk) disable iff (rst)
    (flags.resel && !stat_rd) |=> flags.resel); // R6
  AST_FLAG_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    (!flags.sel && !accepted.sel) |=> !flags.sel); // R5
endmodule

// File: rtl/bcu_role.sv
module bcu_role
  import bcu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  evt_t  accepted,
  input  logic  set_init,
  input  logic  set_tgt,
  output role_e role,
  output logic  role_ok
);
  always_ff @(posedge clk) begin
    if (rst) begin
      role    <= ROLE_INIT;
      role_ok <= 1'b1;
    end else if (accepted.sel) begin
      role    <= ROLE_TGT;
      role_ok <= 1'b0;
    end else if (accepted.resel) begin
      role    <= ROLE_INIT;
      role_ok <= 1'b0;
    end else if (set_tgt) begin
      role    <= ROLE_TGT;
      role_ok <= 1'b1;
    end else if (set_init) begin
      role    <= ROLE_INIT;
      role_ok <= 1'b1;
    end
  end

  AST_ROLE_AFTER_SEL: assert property (@(posedge clk) disable iff (rst)
    accepted.sel |=> (role == ROLE_TGT) && !role_ok); // R8
endmodule

// File: rtl/bus_collide_unit.sv
module bus_collide_unit
  import bcu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              ien_we,
  input  logic [REG_W-1:0]  ien_wdata,
  input  logic              set_init,
  input  logic              set_tgt,
  input  logic              start_req,
  input  logic [ADDR_W-1:0] start_alt,
  input  logic              attempt_done,
  input  logic              mon_sel,
  input  logic              mon_resel,
  input  logic              stat_rd,
  output logic [REG_W-1:0]  stat_q,
  output logic              irq,
  output logic              role_tgt,
  output logic              role_ok,
  output logic              busy,
  output logic              alt_jump,
  output logic [ADDR_W-1:0] alt_addr,
  output logic              done_pulse
);
  evt_t  resp_en;
  evt_t  int_en;
  evt_t  accepted;
  logic  collide;
  logic  finish;
  role_e role;
  logic  start_ok;

  bcu_cfg_regs #(.REG_W(REG_W)) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ien_we(ien_we), .ien_wdata(ien_wdata),
    .resp_en(resp_en), .int_en(int_en)
  );

  bcu_event_arb u_arb (
    .mon_sel(mon_sel), .mon_resel(mon_resel), .resp_en(resp_en),
    .busy(busy), .attempt_done(attempt_done),
    .accepted(accepted), .collide(collide), .finish(finish)
  );

  bcu_status #(.REG_W(REG_W)) u_stat (
    .clk(clk), .rst(rst), .accepted(accepted), .stat_rd(stat_rd),
    .int_en(int_en), .stat_q(stat_q), .irq(irq)
  );

  bcu_role u_role (
    .clk(clk), .rst(rst), .accepted(accepted),
    .set_init(set_init), .set_tgt(set_tgt),
    .role(role), .role_ok(role_ok)
  );

  assign role_tgt = (role == ROLE_TGT);
  assign start_ok = start_req & ~busy & role_ok & ~(accepted.sel | accepted.resel);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      alt_jump   <= 1'b0;
      done_pulse <= 1'b0;
      alt_addr   <= '0;
    end else begin
      alt_jump   <= collide;
      done_pulse <= finish;
      if (collide || finish) begin
        busy <= 1'b0;
      end else if (start_ok) begin
        busy     <= 1'b1;
        alt_addr <= start_alt;
      end
    end
  end

  AST_JUMP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    alt_jump |=> !alt_jump); // R3
  AST_JUMP_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    alt_jump |-> !busy); // R4
  AST_JUMP_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
    !(alt_jump && done_pulse)); // R9
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(alt_addr)); // R2
  AST_LOCKED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !role_ok |-> !busy); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> !busy && !alt_jump); // R10
endmodule

// File: tb/bus_collide_unit_test.sv
`timescale 1ns/1ps
module bus_collide_unit_test;
  localparam int ADDR_W = 16;
  localparam int REG_W  = 8;

  logic clk = 1'b0;
  logic rst;
  logic cfg_we, ien_we, set_init, set_tgt, start_req, attempt_done;
  logic mon_sel, mon_resel, stat_rd;
  logic [REG_W-1:0]  cfg_wdata, ien_wdata, stat_q;
  logic [ADDR_W-1:0] start_alt, alt_addr;
  logic irq, role_tgt, role_ok, busy, alt_jump, done_pulse;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  bus_collide_unit #(.ADDR_W(ADDR_W), .REG_W(REG_W)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .set_init(set_init),
    .set_tgt(set_tgt), .start_req(start_req), .start_alt(start_alt),
    .attempt_done(attempt_done), .mon_sel(mon_sel), .mon_resel(mon_resel),
    .stat_rd(stat_rd), .stat_q(stat_q), .irq(irq), .role_tgt(role_tgt),
    .role_ok(role_ok), .busy(busy), .alt_jump(alt_jump),
    .alt_addr(alt_addr), .done_pulse(done_pulse)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_we = 0; ien_we = 0; set_init = 0; set_tgt = 0; start_req = 0;
    attempt_done = 0; mon_sel = 0; mon_resel = 0; stat_rd = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_we = 1; cfg_wdata = v; step();
  endtask

  task automatic write_ien(input logic [7:0] v);
    ien_we = 1; ien_wdata = v; step();
  endtask

  task automatic clear_and_init();
    stat_rd = 1; step();
    set_init = 1; step();
  endtask

  task automatic t_reset();
    chk("R1", "stat", stat_q, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "jump", alt_jump, 0);
    chk("R1", "done", done_pulse, 0);
    chk("R1", "role_tgt", role_tgt, 0);
    chk("R1", "role_ok", role_ok, 1);
  endtask

  task automatic t_init_collision();
    write_cfg(8'h60);
    start_req = 1; start_alt = 16'h1234; step();
    chk("R2", "busy after start", busy, 1);
    mon_resel = 1; step();
    chk("R3", "jump", alt_jump, 1);
    chk("R3", "addr", alt_addr, 16'h1234);
    chk("R3", "busy", busy, 0);
    chk("R6", "resel flag", stat_q, 8'h10);
    chk("R8", "role init", role_tgt, 0);
    chk("R8", "role_ok low", role_ok, 0);
    step();
    chk("R3", "jump one cycle", alt_jump, 0);
    clear_and_init();
  endtask

  task automatic t_target_collision();
    set_tgt = 1; step();
    chk("R8", "set_tgt role", role_tgt, 1);
    chk("R8", "set_tgt ok", role_ok, 1);
    start_req = 1; start_alt = 16'hBEEF; step();
    mon_sel = 1; step();
    chk("R4", "jump", alt_jump, 1);
    chk("R4", "addr", alt_addr, 16'hBEEF);
    chk("R4", "busy", busy, 0);
    chk("R6", "sel flag", stat_q, 8'h20);
    chk("R8", "role tgt", role_tgt, 1);
    step();
    chk("R4", "jump one cycle", alt_jump, 0);
    clear_and_init();
  endtask

  task automatic t_enable_gate();
    write_cfg(8'h20);
    start_req = 1; start_alt = 16'h0AAA; step();
    mon_resel = 1; step();
    chk("R5", "no jump", alt_jump, 0);
    chk("R5", "still busy", busy, 1);
    chk("R5", "no flag", stat_q, 0);
    chk("R5", "role_ok kept", role_ok, 1);
    attempt_done = 1; step();
    chk("R10", "done", done_pulse, 1);
    write_cfg(8'h40);
    mon_sel = 1; step();
    chk("R5", "sel ignored flag", stat_q, 0);
    chk("R5", "sel ignored role", role_tgt, 0);
    chk("R5", "sel ignored ok", role_ok, 1);
    write_cfg(8'h60);
  endtask

  task automatic t_flags();
    mon_sel = 1; step();
    chk("R6", "sel set", stat_q, 8'h20);
    chk("R8", "idle sel role", role_tgt, 1);
    step();
    chk("R6", "sticky", stat_q, 8'h20);
    mon_resel = 1; stat_rd = 1; step();
    chk("R6", "set beats clear", stat_q, 8'h10);
    stat_rd = 1; step();
    chk("R6", "cleared", stat_q, 0);
    set_init = 1; step();
  endtask

  task automatic t_irq();
    write_ien(8'h10);
    mon_sel = 1; step();
    chk("R7", "masked", irq, 0);
    mon_resel = 1; step();
    chk("R7", "resel irq", irq, 1);
    stat_rd = 1; step();
    chk("R7", "irq cleared", irq, 0);
    write_ien(8'h20);
    mon_sel = 1; step();
    chk("R7", "sel irq", irq, 1);
    write_ien(8'h00);
    chk("R7", "irq disabled", irq, 0);
    clear_and_init();
  endtask

  task automatic t_role_lock();
    mon_resel = 1; step();
    chk("R8", "locked", role_ok, 0);
    start_req = 1; start_alt = 16'h0F0F; step();
    chk("R2", "start ignored locked", busy, 0);
    set_init = 1; set_tgt = 1; step();
    chk("R8", "tgt wins", role_tgt, 1);
    chk("R8", "unlocked", role_ok, 1);
    stat_rd = 1; step();
    mon_sel = 1; mon_resel = 1; step();
    chk("R8", "both events target", role_tgt, 1);
    chk("R8", "both flags", stat_q, 8'h30);
    clear_and_init();
  endtask

  task automatic t_same_cycle();
    start_req = 1; start_alt = 16'h5555; step();
    start_req = 1; start_alt = 16'h7777; step();
    chk("R2", "busy start ignored", alt_addr, 16'h5555);
    mon_resel = 1; attempt_done = 1; step();
    chk("R9", "jump wins", alt_jump, 1);
    chk("R9", "no done", done_pulse, 0);
    chk("R9", "busy cleared", busy, 0);
    chk("R9", "addr", alt_addr, 16'h5555);
    clear_and_init();
  endtask

  task automatic t_normal_done();
    start_req = 1; start_alt = 16'h2222; step();
    attempt_done = 1; step();
    chk("R10", "done", done_pulse, 1);
    chk("R10", "no jump", alt_jump, 0);
    chk("R10", "idle", busy, 0);
    step();
    chk("R10", "done one cycle", done_pulse, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle_inputs();
    cfg_wdata = 0; ien_wdata = 0; start_alt = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_init_collision();
    t_target_collision();
    t_enable_gate();
    t_flags();
    t_irq();
    t_role_lock();
    t_same_cycle();
    t_normal_done();
    summary();
  end
endmodule